// File: doc/BRIEF.md
# Three-Deep Shadow Set Sequencer

This block keeps up to three queued parameter sets for a PWM generator and feeds them, one at a time, into an active register set that the counter and compare logic read. Each set holds one period word, a configurable number of compare words and one action-configuration word. Software fills the three shadow sets through a simple word-write port, then issues a load command. From then on, each period-boundary strobe from the time base may move one set into the active registers. The sets go in descending order: set 3 first, then set 2, then set 1.

Sets 3 and 2 can each stay active for a programmable number of extra periods before the sequence moves on. After set 1 has been applied, the active values stay frozen until software issues the next load command. The block reports three full flags and a buffer pointer so that software can see how far the queue has drained. A load command that arrives while a sequence is still running discards the remaining queue and starts again from set 3.

Top module: `shset_seq_top`

## Requirements
- R1: After reset, all three full flags are 0, the buffer pointer reads 1, and every active word is 0.
- R2: A load command sets all three full flags and sets the pointer to 3 on the following clock edge. It does not change the active words. A full flag is never set by anything other than a load command.
- R3: At the first boundary after a load, the active words take the contents of shadow set 3. Flag 3 (full_flags bit 2) clears and the pointer stays 3.
- R4: Set 3 stays active for rpt3+1 boundaries. Boundaries during the extra periods change neither the flags, the pointer nor the active words. A repeat value of 0 means one period.
- R5: At the next boundary, set 2 is copied into the active words, flag 2 (bit 1) clears and the pointer becomes 2. Set 2 then stays active for rpt2+1 boundaries.
- R6: At the next boundary, set 1 is copied into the active words, flag 1 (bit 0) clears and the pointer becomes 1. The pointer never reads 0.
- R7: While all flags are clear, boundaries cause no transfer. The active words hold and the pointer stays 1.
- R8: When a load command and a boundary arrive in the same cycle, the load is taken and no transfer happens in that cycle. Set 3 transfers at the next boundary.
- R9: Shadow writes never change the active words directly. A write with wr_set=0 is ignored. A write with a field index above N_CMP+1 is ignored. Field 0 is the period word, fields 1..N_CMP are the compare words, and field N_CMP+1 is the action word.
- R10: A load command issued in the middle of a sequence clears any pending repeat. The next boundary transfers set 3 with its current shadow contents.
- R11: Without a boundary, the active words do not change from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Shadow word write strobe |
| wr_set | input | 2 | Target shadow set (1..3; 0 is ignored) |
| wr_field | input | FSEL_W | Field index: 0 period, 1..N_CMP compare, N_CMP+1 action |
| wr_data | input | DATA_W | Word to write |
| load_cmd | input | 1 | Arms all three sets and restarts the sequence |
| prd_tick | input | 1 | Period-boundary strobe from the time base |
| rpt2 | input | RPT_W | Extra periods for set 2 |
| rpt3 | input | RPT_W | Extra periods for set 3 |
| act_prd | output | DATA_W | Active period word |
| act_cmp | output | N_CMP*DATA_W | Active compare words, word i at bits i*DATA_W |
| act_aq | output | DATA_W | Active action-configuration word |
| full_flags | output | 3 | Bit k set when shadow set k+1 is still pending |
| buf_ptr | output | 2 | Index of the set most recently applied or armed |

## Verification
The bench targets the following corner cases:

- A load and a boundary in the same cycle. A design that let the boundary win would apply stale data, or would skip set 3.
- Repeat counts of zero and of several periods. An off-by-one here would shorten or stretch a set's stay, and set 2 would appear a period early or late.
- A reload in the middle of a repeat. A design that kept the old repeat count would wrongly hold the previous set.
- Writes with set 0 and writes with out-of-range field indices. A loose decoder would corrupt a neighbouring word.
- Boundaries after the queue has drained. These must leave the pointer at 1 and the active words frozen.

// File: rtl/shset_pkg.sv
package shset_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ONE   = 2'd1,
    SEL_TWO   = 2'd2,
    SEL_THREE = 2'd3
  } set_sel_e;

  // Highest pending set wins: sets drain in descending order.
  function automatic set_sel_e pick_set(input logic [2:0] full);
    if (full[2]) return SEL_THREE;
    if (full[1]) return SEL_TWO;
    if (full[0]) return SEL_ONE;
    return SEL_NONE;
  endfunction

  function automatic logic [2:0] drop_flag(input logic [2:0] full, input set_sel_e s);
    logic [2:0] r;
    r = full;
    case (s)
      SEL_ONE:   r[0] = 1'b0;
      SEL_TWO:   r[1] = 1'b0;
      SEL_THREE: r[2] = 1'b0;
      default:   r = full;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/shset_bank.sv
module shset_bank
  import shset_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NF     = 6,
  parameter int FSEL_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_set,
  input  logic [FSEL_W-1:0]            wr_field,
  input  logic [DATA_W-1:0]            wr_data,
  input  set_sel_e                     rd_sel,
  output logic [NF-1:0][DATA_W-1:0]    rd_words
);

  logic [NF-1:0][DATA_W-1:0] set_q [3];
  logic                      field_ok;

  assign field_ok = (32'(wr_field) < NF);

  for (genvar g = 0; g < 3; g++) begin : g_set
    logic [NF-1:0][DATA_W-1:0] words_q;
    logic                      hit;

    assign hit = wr_en && field_ok && (wr_set == 2'(g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q <= '0;
      end else if (hit) begin
        words_q[wr_field] <= wr_data;
      end
    end

    assign set_q[g] = words_q;
  end

  always_comb begin
    case (rd_sel)
      SEL_ONE:   rd_words = set_q[0];
      SEL_TWO:   rd_words = set_q[1];
      SEL_THREE: rd_words = set_q[2];
      default:   rd_words = '0;
    endcase
  end

endmodule

// File: rtl/shset_ctrl.sv
module shset_ctrl
  import shset_pkg::*;
#(
  parameter int RPT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_cmd,
  input  logic             prd_tick,
  input  logic [RPT_W-1:0] rpt2,
  input  logic [RPT_W-1:0] rpt3,
  output logic [2:0]       full_q,
  output logic [1:0]       ptr_q,
  output logic             xfer_en,
  output set_sel_e         xfer_sel
);

  logic [RPT_W-1:0] rep_q;
  logic             rep_busy;

  assign rep_busy = (rep_q != '0);
  assign xfer_sel = pick_set(full_q);
  assign xfer_en  = prd_tick && !load_cmd && !rep_busy && (xfer_sel != SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 3'b000;
      ptr_q  <= 2'd1;
      rep_q  <= '0;
    end else if (load_cmd) begin
      full_q <= 3'b111;
      ptr_q  <= 2'd3;
      rep_q  <= '0;
    end else if (prd_tick) begin
      if (rep_busy) begin
        rep_q <= rep_q - 1'b1;
      end else if (xfer_en) begin
        full_q <= drop_flag(full_q, xfer_sel);
        ptr_q  <= xfer_sel;
        rep_q  <= (xfer_sel == SEL_THREE) ? rpt3 :
                  (xfer_sel == SEL_TWO)   ? rpt2 : '0;
      end
    end
  end

  assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd |=> (full_q == 3'b111) && (ptr_q == 2'd3));

  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cmd |=> ((full_q & ~$past(full_q)) == 3'b000));

  assert_one_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cmd |=> ($countones($past(full_q) & ~full_q) <= 1));

  assert_repeat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_tick && !load_cmd && rep_busy) |=> $stable(full_q) && $stable(ptr_q));

  assert_ptr_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q != 2'd0);

  assert_drained_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q == 3'b000 && !load_cmd) |=> (full_q == 3'b000) && (ptr_q == 2'd1));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd |-> !xfer_en);

endmodule

// File: rtl/shset_active.sv
module shset_active #(
  parameter int DATA_W = 16,
  parameter int NF     = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xfer_en,
  input  logic [NF-1:0][DATA_W-1:0] src_words,
  output logic [NF-1:0][DATA_W-1:0] act_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (xfer_en) begin
      act_q <= src_words;
    end
  end

  assert_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |=> act_q == $past(src_words));

  assert_active_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> $stable(act_q));

endmodule

// File: rtl/shset_seq_top.sv
module shset_seq_top
  import shset_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_CMP  = 4,
  parameter int RPT_W  = 3,
  localparam int NF     = N_CMP + 2,
  localparam int FSEL_W = $clog2(NF + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_set,
  input  logic [FSEL_W-1:0]       wr_field,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    load_cmd,
  input  logic                    prd_tick,
  input  logic [RPT_W-1:0]        rpt2,
  input  logic [RPT_W-1:0]        rpt3,
  output logic [DATA_W-1:0]       act_prd,
  output logic [N_CMP*DATA_W-1:0] act_cmp,
  output logic [DATA_W-1:0]       act_aq,
  output logic [2:0]              full_flags,
  output logic [1:0]              buf_ptr
);

  logic                      xfer_en;
  set_sel_e                  xfer_sel;
  logic [NF-1:0][DATA_W-1:0] src_words;
  logic [NF-1:0][DATA_W-1:0] act_words;

  shset_bank #(.DATA_W(DATA_W), .NF(NF), .FSEL_W(FSEL_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_set   (wr_set),
    .wr_field (wr_field),
    .wr_data  (wr_data),
    .rd_sel   (xfer_sel),
    .rd_words (src_words)
  );

  shset_ctrl #(.RPT_W(RPT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_cmd (load_cmd),
    .prd_tick (prd_tick),
    .rpt2     (rpt2),
    .rpt3     (rpt3),
    .full_q   (full_flags),
    .ptr_q    (buf_ptr),
    .xfer_en  (xfer_en),
    .xfer_sel (xfer_sel)
  );

  shset_active #(.DATA_W(DATA_W), .NF(NF)) u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_en   (xfer_en),
    .src_words (src_words),
    .act_q     (act_words)
  );

  assign act_prd = act_words[0];
  assign act_aq  = act_words[NF-1];
  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assign act_cmp[i*DATA_W +: DATA_W] = act_words[i+1];
  end

endmodule

// File: tb/tb_shset_seq_top.sv
`timescale 1ns/1ps
module tb_shset_seq_top;

  localparam int DW = 16;
  localparam int NC = 4;
  localparam int RW = 3;
  localparam int NF = NC + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_set = '0;
  logic [2:0]    wr_field = '0;
  logic [DW-1:0] wr_data = '0;
  logic          load_cmd = 1'b0;
  logic          prd_tick = 1'b0;
  logic [RW-1:0] rpt2 = '0;
  logic [RW-1:0] rpt3 = '0;
  logic [DW-1:0]    act_prd;
  logic [NC*DW-1:0] act_cmp;
  logic [DW-1:0]    act_aq;
  logic [2:0]       full_flags;
  logic [1:0]       buf_ptr;

  always #2.5 clk = ~clk;

  shset_seq_top #(.DATA_W(DW), .N_CMP(NC), .RPT_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_field(wr_field),
    .wr_data(wr_data), .load_cmd(load_cmd), .prd_tick(prd_tick), .rpt2(rpt2), .rpt3(rpt3),
    .act_prd(act_prd), .act_cmp(act_cmp), .act_aq(act_aq),
    .full_flags(full_flags), .buf_ptr(buf_ptr)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [DW-1:0] sh [1:3][0:NF-1];
  logic [DW-1:0] ea [0:NF-1];
  logic [2:0]    ef;
  logic [1:0]    ep;
  int            er;

  function automatic logic [NF*DW-1:0] pack_exp();
    logic [NF*DW-1:0] v;
    for (int i = 0; i < NF; i++) v[i*DW +: DW] = ea[i];
    return v;
  endfunction

  function automatic int highest_pending(input logic [2:0] f);
    if (f[2]) return 3;
    if (f[1]) return 2;
    if (f[0]) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int s = 1; s <= 3; s++) for (int f = 0; f < NF; f++) sh[s][f] = '0;
    for (int f = 0; f < NF; f++) ea[f] = '0;
    ef = 3'b000; ep = 2'd1; er = 0;
  endtask

  task automatic model_edge(input bit we, input logic [1:0] ws, input logic [2:0] wf,
                            input logic [DW-1:0] wd, input bit ld, input bit tk);
    int k;
    if (ld) begin
      ef = 3'b111; ep = 2'd3; er = 0;
    end else if (tk) begin
      if (er != 0) er--;
      else begin
        k = highest_pending(ef);
        if (k != 0) begin
          for (int f = 0; f < NF; f++) ea[f] = sh[k][f];
          ef[k-1] = 1'b0;
          ep = 2'(k);
          er = (k == 3) ? int'(rpt3) : (k == 2) ? int'(rpt2) : 0;
        end
      end
    end
    if (we && ws != 2'd0 && int'(wf) < NF) sh[ws][wf] = wd;
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "flags", 128'(full_flags), 128'(ef));
    chk(tag, "ptr", 128'(buf_ptr), 128'(ep));
    chk(tag, "active", 128'({act_aq, act_cmp, act_prd}), 128'(pack_exp()));
  endtask

  task automatic step(input bit we, input logic [1:0] ws, input logic [2:0] wf,
                      input logic [DW-1:0] wd, input bit ld, input bit tk, input string tag);
    @(negedge clk);
    wr_en = we; wr_set = ws; wr_field = wf; wr_data = wd; load_cmd = ld; prd_tick = tk;
    @(posedge clk);
    model_edge(we, ws, wf, wd, ld, tk);
    #1;
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'd0, 3'd0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic tick(input string tag);
    step(1'b0, 2'd0, 3'd0, '0, 1'b0, 1'b1, tag);
  endtask

  task automatic fill_sets(input logic [7:0] base);
    for (int s = 1; s <= 3; s++)
      for (int f = 0; f < NF; f++)
        step(1'b1, 2'(s), 3'(f), {base, 4'(s), 4'(f)}, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 compare_all("R1");
    idle("R1");

    // Shadow fill never reaches the active words.
    fill_sets(8'hA0);
    // Ignored writes: set 0 and field indices 6 and 7.
    step(1'b1, 2'd0, 3'd0, 16'hDEAD, 1'b0, 1'b0, "R9");
    step(1'b1, 2'd3, 3'd6, 16'hBEEF, 1'b0, 1'b0, "R9");
    step(1'b1, 2'd2, 3'd7, 16'hCAFE, 1'b0, 1'b0, "R9");

    rpt3 = 3'd1; rpt2 = 3'd2;
    step(1'b0, 2'd0, 3'd0, '0, 1'b1, 1'b0, "R2");
    idle("R11");
    tick("R3");
    idle("R11");
    tick("R4");
    tick("R5");
    tick("R5");
    tick("R5");
    tick("R6");
    tick("R7");
    tick("R7");
    idle("R11");

    // Load coincident with a boundary; zero repeats.
    rpt3 = 3'd0; rpt2 = 3'd0;
    step(1'b0, 2'd0, 3'd0, '0, 1'b1, 1'b1, "R8");
    tick("R8");
    tick("R5");
    tick("R6");
    tick("R7");

    // Reload in the middle of a repeat.
    rpt3 = 3'd3;
    step(1'b0, 2'd0, 3'd0, '0, 1'b1, 1'b0, "R2");
    tick("R3");
    tick("R4");
    step(1'b1, 2'd3, 3'd0, 16'h5A5A, 1'b0, 1'b0, "R9");
    step(1'b0, 2'd0, 3'd0, '0, 1'b1, 1'b0, "R10");
    tick("R10");
    tick("R4");

    // Random traffic.
    for (int n = 0; n < 4000; n++) begin
      automatic bit           we = ($urandom % 2) == 0;
      automatic logic [1:0]   ws = 2'($urandom % 4);
      automatic logic [2:0]   wf = 3'($urandom % 8);
      automatic logic [DW-1:0] wd = DW'($urandom);
      automatic bit           ld = ($urandom % 40) == 0;
      automatic bit           tk = ($urandom % 4) == 0;
      if (($urandom % 64) == 0) begin
        rpt2 = RW'($urandom); rpt3 = RW'($urandom);
      end
      step(we, ws, wf, wd, ld, tk, "R11");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule